// File: doc/BRIEF.md
# Dual-Channel Overscale Flag Generator

This block watches the conversion results of two independent audio channels, left and right. It raises a per-channel flag when that channel's output saturates. Each channel's samples arrive as signed two's-complement words with a one-cycle valid strobe, once per frame. A sample counts as over-range when it sits on either saturation code.

The flag rises only after two back-to-back over-range results on the same channel. After that it stays up for a fixed number of frame-clock ticks and does not follow the data.

A level input puts the digital section into power-down. While that input is high, both flags are held low and all tracking state is discarded. Downstream logic can use the flags to drive clip indicators or gain-reduction decisions.

Top module: `ovs_flag_gen`

## Requirements
- R1: A sample counts as over-range exactly when it equals the positive saturation code 2^(W-1)-1 (18'h1FFFF at W=18) or the negative saturation code -2^(W-1) (18'h20000). Any other code, including the neighbours of the saturation codes, is in range. A positive saturation code followed by a negative one still forms a qualifying pair.
- R2: When a channel's valid strobe carries an over-range sample and that channel's previous valid sample was also over-range, the channel's flag output is high from the clock edge that captures the second sample.
- R3: An in-range valid sample clears the channel's consecutive tracking. A single over-range sample that sits between in-range samples never sets the flag.
- R4: Once set, the flag stays high through exactly HOLD_FRAMES frame ticks counted after the setting edge. It drops at the edge that captures the HOLD_FRAMES-th tick. Clock cycles without a tick do not shorten the hold.
- R5: A further qualifying over-range sample while the flag is high reloads the hold to a full HOLD_FRAMES ticks. This includes a third over-range sample in a row. If a qualifying sample and a tick arrive in the same cycle, the reload wins.
- R6: The left and right channels are independent: stimulus on one channel never changes the other channel's flag.
- R7: While pd_i is high, both flag outputs are low in the same cycle, and samples and ticks are ignored. Each channel's hold and consecutive tracking are cleared. After pd_i falls, a flag needs a fresh pair of over-range samples to rise.
- R8: During and directly after reset (rst_ni low), both flags are low and the consecutive tracking is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Digital power-down, active high |
| frame_tick_i | input | 1 | One-cycle pulse per frame-clock period |
| smp_l_i | input | SMP_W | Left conversion result, two's complement |
| smp_l_vld_i | input | 1 | Left result valid strobe |
| smp_r_i | input | SMP_W | Right conversion result, two's complement |
| smp_r_vld_i | input | 1 | Right result valid strobe |
| ovf_l_o | output | 1 | Left overscale flag |
| ovf_r_o | output | 1 | Right overscale flag |

## Verification
A sweep of eight codes around both saturation points separates a true saturation test from a sign or magnitude compare. All sixteen four-sample over/in-range patterns are applied to the left channel while the right channel gets the complementary pattern. This separates pair detection from single-hit detection and exposes any leakage between channels.

Tick sequences with idle cycles in between show whether the hold counts frames or clock cycles, and whether it ends on the exact tick. Further cases cover a retrigger in mid-hold, a set that coincides with a tick, and a power-down pulse with live stimulus. Together these pin down the reload priority and the clearing of the tracking state.

// File: rtl/ovs_pkg.sv
`timescale 1ns/1ps
package ovs_pkg;
  localparam int unsigned CH_N = 2;
  typedef enum int unsigned {
    CH_LEFT  = 0,
    CH_RIGHT = 1
  } ch_e;
endpackage

// File: rtl/ovs_range_det.sv
`timescale 1ns/1ps
module ovs_range_det #(
  parameter int unsigned SMP_W = 18
) (
  input  logic [SMP_W-1:0] smp_i,
  output logic             over_o
);
  localparam logic [SMP_W-1:0] POS_SAT = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] NEG_SAT = {1'b1, {(SMP_W-1){1'b0}}};

  always_comb over_o = (smp_i == POS_SAT) || (smp_i == NEG_SAT);

  always_comb begin
    if (over_o) a_r1_sat_code_only: assert (smp_i[SMP_W-1] != smp_i[SMP_W-2] || SMP_W < 2);
  end
endmodule

// File: rtl/ovs_pair_track.sv
`timescale 1ns/1ps
module ovs_pair_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic vld_i,
  input  logic over_i,
  output logic trig_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= 1'b0;
    else if (pd_i)  prev_q <= 1'b0;
    else if (vld_i) prev_q <= over_i;
  end

  always_comb trig_o = vld_i & over_i & prev_q & ~pd_i;

  a_r3_in_range_breaks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !over_i && !pd_i) |=> !trig_o);
  a_r7_pd_breaks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !trig_o);
endmodule

// File: rtl/ovs_hold_timer.sv
`timescale 1ns/1ps
module ovs_hold_timer #(
  parameter int unsigned HOLD_FRAMES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic set_i,
  input  logic tick_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(HOLD_FRAMES + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(HOLD_FRAMES);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pd_i) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (set_i) begin
      flag_q <= 1'b1;
      cnt_q  <= CNT_FULL;
    end else if (tick_i && flag_q) begin
      if (cnt_q == CNT_ONE) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q - CNT_ONE;
      end
    end
  end

  always_comb flag_o = flag_q;

  a_r7_pd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !flag_q);
  a_r4_ends_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(pd_i) || $past(tick_i && cnt_q == CNT_ONE)));
  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> (cnt_q != '0 && cnt_q <= CNT_FULL));
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !pd_i) |=> (flag_q && cnt_q == CNT_FULL));
endmodule

// File: rtl/ovs_chan.sv
`timescale 1ns/1ps
module ovs_chan #(
  parameter int unsigned SMP_W       = 18,
  parameter int unsigned HOLD_FRAMES = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             tick_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             vld_i,
  output logic             flag_o
);
  logic over;
  logic trig;

  ovs_range_det #(.SMP_W(SMP_W)) i_det (
    .smp_i  (smp_i),
    .over_o (over)
  );

  ovs_pair_track i_pair (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pd_i),
    .vld_i  (vld_i),
    .over_i (over),
    .trig_o (trig)
  );

  ovs_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pd_i   (pd_i),
    .set_i  (trig),
    .tick_i (tick_i),
    .flag_o (flag_o)
  );

  a_r2_rise_needs_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(vld_i && over && !pd_i));
endmodule

// File: rtl/ovs_flag_gen.sv
`timescale 1ns/1ps
module ovs_flag_gen
  import ovs_pkg::*;
#(
  parameter int unsigned SMP_W       = 18,
  parameter int unsigned HOLD_FRAMES = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             frame_tick_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic             smp_l_vld_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             smp_r_vld_i,
  output logic             ovf_l_o,
  output logic             ovf_r_o
);
  logic [SMP_W-1:0] smp_a  [CH_N];
  logic             vld_a  [CH_N];
  logic             flag_a [CH_N];

  always_comb begin
    smp_a[CH_LEFT]  = smp_l_i;
    smp_a[CH_RIGHT] = smp_r_i;
    vld_a[CH_LEFT]  = smp_l_vld_i;
    vld_a[CH_RIGHT] = smp_r_vld_i;
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    ovs_chan #(
      .SMP_W       (SMP_W),
      .HOLD_FRAMES (HOLD_FRAMES)
    ) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pd_i   (pd_i),
      .tick_i (frame_tick_i),
      .smp_i  (smp_a[ch]),
      .vld_i  (vld_a[ch]),
      .flag_o (flag_a[ch])
    );
  end

  // power-down masks the flags without waiting for an edge
  always_comb begin
    ovf_l_o = flag_a[CH_LEFT]  & ~pd_i;
    ovf_r_o = flag_a[CH_RIGHT] & ~pd_i;
  end

  a_r8_reset_low: assert property (@(posedge clk_i)
    !rst_ni |=> (!ovf_l_o && !ovf_r_o) || $past(rst_ni) || rst_ni);
endmodule

// File: tb/test_ovs_flag_gen.sv
`timescale 1ns/1ps
module test_ovs_flag_gen;
  localparam int HOLD = 5;
  localparam logic [17:0] OV_P = 18'h1FFFF;
  localparam logic [17:0] OV_N = 18'h20000;
  localparam logic [17:0] INR  = 18'h1FFFE;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pd = 1'b0, tick = 1'b0, vl = 1'b0, vr = 1'b0;
  logic [17:0] sl = '0, sr = '0;
  logic ovf_l, ovf_r;

  int nchk = 0, nerr = 0;
  logic mprev [2];
  logic mflag [2];
  int   mcnt  [2];

  always #5 clk = ~clk;

  ovs_flag_gen #(.SMP_W(18), .HOLD_FRAMES(HOLD)) i_ovs_flag_gen (
    .clk_i(clk), .rst_ni(rst_ni), .pd_i(pd), .frame_tick_i(tick),
    .smp_l_i(sl), .smp_l_vld_i(vl), .smp_r_i(sr), .smp_r_vld_i(vr),
    .ovf_l_o(ovf_l), .ovf_r_o(ovf_r)
  );

  function automatic logic is_over(input logic [17:0] s);
    return (s == 18'h1FFFF) || (s == 18'h20000);
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %0b exp %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(input int c, input logic v, input logic [17:0] s,
                       input logic tk, input logic p);
    logic trig;
    if (p) begin
      mprev[c] = 1'b0; mflag[c] = 1'b0; mcnt[c] = 0;
    end else begin
      trig = v && is_over(s) && mprev[c];
      if (v) mprev[c] = is_over(s);
      if (trig) begin
        mflag[c] = 1'b1; mcnt[c] = HOLD;
      end else if (tk && mflag[c]) begin
        mcnt[c]--;
        if (mcnt[c] == 0) mflag[c] = 1'b0;
      end
    end
  endtask

  task automatic step(input logic v_l, input logic [17:0] s_l,
                      input logic v_r, input logic [17:0] s_r,
                      input logic tk, input logic p, input string tag);
    @(negedge clk);
    vl = v_l; sl = s_l; vr = v_r; sr = s_r; tick = tk; pd = p;
    model(0, v_l, s_l, tk, p);
    model(1, v_r, s_r, tk, p);
    @(posedge clk);
    #1;
    chk(ovf_l, mflag[0] && !p, {tag, " left"});
    chk(ovf_r, mflag[1] && !p, {tag, " right"});
  endtask

  task automatic clear();
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "R7 clear");
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R7 after clear");
  endtask

  initial begin
    logic [17:0] codes [8];
    codes = '{18'h1FFFF, 18'h20000, 18'h1FFFE, 18'h20001,
              18'h00000, 18'h3FFFF, 18'h00001, 18'h1FFFD};
    for (int c = 0; c < 2; c++) begin
      mprev[c] = 1'b0; mflag[c] = 1'b0; mcnt[c] = 0;
    end

    // R8: reset with live over-range stimulus
    vl = 1'b1; sl = OV_P; vr = 1'b1; sr = OV_N;
    repeat (3) @(posedge clk);
    #1;
    chk(ovf_l, 1'b0, "R8 reset left");
    chk(ovf_r, 1'b0, "R8 reset right");
    @(negedge clk);
    vl = 1'b0; vr = 1'b0;
    rst_ni = 1'b1;
    step(1'b1, OV_P, 1'b0, '0, 1'b0, 1'b0, "R8 first after reset");

    // R1: code sweep on left, right idle (R6)
    clear();
    for (int i = 0; i < 8; i++) begin
      step(1'b1, codes[i], 1'b0, '0, 1'b0, 1'b0, "R1 sweep a");
      step(1'b1, codes[i], 1'b0, '0, 1'b0, 1'b0, "R1 sweep b R6");
      clear();
    end
    // R1: positive then negative saturation on right
    step(1'b0, '0, 1'b1, OV_P, 1'b0, 1'b0, "R1 mixed a");
    step(1'b0, '0, 1'b1, OV_N, 1'b0, 1'b0, "R1 mixed b");
    clear();

    // R2/R3/R6: all four-sample patterns, right gets complement
    for (int p = 0; p < 16; p++) begin
      for (int b = 0; b < 4; b++) begin
        step(1'b1, p[b] ? OV_N : INR, 1'b1, p[b] ? INR : OV_P,
             1'b0, 1'b0, "R2/R3/R6 pattern");
        step(1'b0, OV_P, 1'b0, OV_P, 1'b0, 1'b0, "R3 gap no strobe");
      end
      clear();
    end

    // R4: hold length, ticks separated by idle cycles
    step(1'b1, OV_P, 1'b0, '0, 1'b0, 1'b0, "R4 set a");
    step(1'b1, OV_P, 1'b0, '0, 1'b0, 1'b0, "R4 set b");
    step(1'b1, INR, 1'b0, '0, 1'b0, 1'b0, "R4 break pair");
    for (int k = 0; k < HOLD + 2; k++) begin
      step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R4 tick");
      step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R4 idle");
      step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R4 idle");
    end
    clear();

    // R5: set coinciding with tick, then mid-hold retrigger by third over sample
    step(1'b0, '0, 1'b1, OV_N, 1'b1, 1'b0, "R5 set a");
    step(1'b0, '0, 1'b1, OV_N, 1'b1, 1'b0, "R5 set with tick");
    for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R5 tick");
    step(1'b0, '0, 1'b1, OV_P, 1'b0, 1'b0, "R5 retrigger");
    for (int k = 0; k < HOLD + 1; k++) step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R5 tick after reload");
    clear();

    // R7: power-down with live stimulus
    step(1'b1, OV_P, 1'b1, OV_N, 1'b0, 1'b0, "R7 set a");
    step(1'b1, OV_P, 1'b1, OV_N, 1'b0, 1'b0, "R7 set b");
    for (int k = 0; k < 4; k++) step(1'b1, OV_P, 1'b1, OV_N, 1'b1, 1'b1, "R7 pd active");
    step(1'b1, OV_N, 1'b1, OV_P, 1'b0, 1'b0, "R7 single after pd");
    step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R7 stays low");
    step(1'b1, OV_P, 1'b1, INR, 1'b0, 1'b0, "R7 fresh pair");
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R7 fresh pair held");

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule